// File: doc/BRIEF.md
# Split Match-Compare Timer

This block holds two down-counting timers, A and B, each half-width (16 bits by default). Each timer has a load value, a match value and a mode chosen from one-shot, periodic, edge-count and PWM. When a timer's counter equals its match value, a match event sets a sticky interrupt status bit. The status bit is cleared by a write-one-to-clear register, and each interrupt output is its status bit gated by a mask bit. In PWM mode a timer drives a square wave whose duty cycle is set by where the match value sits within the load period.

The two halves can be joined into one full-width timer. In joined mode timer A counts across both halves. B's load and match storage supply the upper halves of A's load and match values, and timer B stops counting. Software controls everything through a small flat register port: a write strobe, a 3-bit address and full-width write and read data. Reads are combinational from the address.

Top module: `split_match_timer`

## Requirements
- R1: After reset, both load and both match values read 0x0000FFFF, CFG (address 0) reads 0, STATUS (address 5) reads 0, and irq_a, irq_b, pwm_a, pwm_b are low. Address map: 0 CFG, 1 LOAD_A, 2 MATCH_A, 3 LOAD_B, 4 MATCH_B, 5 STATUS, 6 ICLR, 7 COUNT. CFG bits: 0 joined, 2:1 mode A, 4:3 mode B, 5 enable A, 6 enable B, 7 mask A, 8 mask B. Mode codes: 0 one-shot, 1 periodic, 2 edge-count, 3 PWM. STATUS and ICLR use bit 0 for A and bit 1 for B. COUNT reads {counter B, counter A low half} when split and the full counter A when joined.
- R2: While a timer is disabled, its counter holds the load value. Once enabled in one-shot mode it counts down by one per cycle. The match event, when the counter equals the match value, shows in STATUS exactly load−match+1 cycles after the clock edge that wrote the enable.
- R3: A one-shot timer holds at zero after reaching it and raises no further match events.
- R4: In periodic mode the counter reloads the load value on the cycle after it is zero, so match events repeat every load+1 cycles.
- R5: In edge-count mode the counter decrements once per rising edge of its event input, seen through a two-flop synchronizer. After load−match edges the match event fires and the timer's enable bit clears itself.
- R6: In edge-count mode, if load is not greater than match, edges are not counted and no match event occurs.
- R7: In PWM mode, pwm is high on the cycle after the counter exceeds the match value and low otherwise, so each load+1 period holds load−match high cycles. A match value of zero gives a constant high output.
- R8: In joined mode timer A counts the full-width value {LOAD_B, LOAD_A} against {MATCH_B, MATCH_A}. A write to LOAD_A or MATCH_A also fills the upper half from write data bits 31:16. Writes to MATCH_B are ignored, and MATCH_B reads return the live upper half of the match value.
- R9: In split mode, bits 31:16 of every match and load register read as zero and ignore writes.
- R10: A match event sets its STATUS bit. Writing 1 to an ICLR bit clears only that bit, and a set in the same cycle wins over the clear. Each irq output equals its STATUS bit ANDed with its mask bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| evt_in_a | input | 1 | Edge-count event input of timer A |
| evt_in_b | input | 1 | Edge-count event input of timer B |
| irq_a | output | 1 | Masked match interrupt of timer A |
| irq_b | output | 1 | Masked match interrupt of timer B |
| pwm_a | output | 1 | PWM output of timer A |
| pwm_b | output | 1 | PWM output of timer B |

## Verification
A wrong counter value shows up as a match status bit that sets one or more cycles early or late. It is caught on the exact cycle, because every interval check samples STATUS both one cycle before and on the cycle of the expected set. A wrong reload or stop state appears within one period as a missing or extra event, or as a COUNT read that differs from zero or from the load value. A bad joined-mode upper half moves the event by 65536 cycles, so the three-cycle check reports it at once. A wrong PWM comparison changes the high-cycle count in the first measured window.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [1:0] {
    MODE_ONESHOT  = 2'd0,
    MODE_PERIODIC = 2'd1,
    MODE_EDGE     = 2'd2,
    MODE_PWM      = 2'd3
  } tmr_mode_e;

  localparam logic [2:0] ADR_CFG     = 3'd0;
  localparam logic [2:0] ADR_LOAD_A  = 3'd1;
  localparam logic [2:0] ADR_MATCH_A = 3'd2;
  localparam logic [2:0] ADR_LOAD_B  = 3'd3;
  localparam logic [2:0] ADR_MATCH_B = 3'd4;
  localparam logic [2:0] ADR_STATUS  = 3'd5;
  localparam logic [2:0] ADR_ICLR    = 3'd6;
  localparam logic [2:0] ADR_COUNT   = 3'd7;

endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic [2:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= 3'b000;
    else        sh_q <= {sh_q[1:0], din};
  end

  // sh_q[1] is the synchronized level, sh_q[2] its previous value
  assign rise = sh_q[1] & ~sh_q[2];
endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import tmr_pkg::*;
#(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  tmr_mode_e    mode,
  input  logic [N-1:0] load_val,
  input  logic [N-1:0] match_val,
  input  logic         edge_pulse,
  output logic         match_evt,
  output logic         stop,
  output logic         pwm_o,
  output logic [N-1:0] cnt_o
);
  localparam logic [N-1:0] ONE = {{(N-1){1'b0}}, 1'b1};

  logic [N-1:0] cnt_q, cnt_d, dec;
  logic         done_q, done_d;
  logic         pwm_q, pwm_d;
  logic         ec_ok;

  assign dec   = cnt_q - ONE;
  assign ec_ok = load_val > match_val;

  always_comb begin
    cnt_d     = cnt_q;
    done_d    = done_q;
    pwm_d     = 1'b0;
    match_evt = 1'b0;
    stop      = 1'b0;
    if (!en) begin
      cnt_d  = load_val;
      done_d = 1'b0;
    end else begin
      unique case (mode)
        MODE_ONESHOT: begin
          if (!done_q) begin
            match_evt = (cnt_q == match_val);
            if (cnt_q == '0) done_d = 1'b1;
            else             cnt_d  = dec;
          end
        end
        MODE_PERIODIC, MODE_PWM: begin
          match_evt = (cnt_q == match_val);
          cnt_d     = (cnt_q == '0) ? load_val : dec;
          if (mode == MODE_PWM)
            pwm_d = (cnt_q > match_val) || (match_val == '0);
        end
        MODE_EDGE: begin
          if (ec_ok && edge_pulse) begin
            cnt_d = dec;
            if (dec == match_val) begin
              match_evt = 1'b1;
              stop      = 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
      pwm_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
      pwm_q  <= pwm_d;
    end
  end

  assign pwm_o = pwm_q;
  assign cnt_o = cnt_q;
endmodule

// File: rtl/split_match_timer.sv
module split_match_timer
  import tmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_we,
  input  logic [2:0]      reg_addr,
  input  logic [2*W-1:0]  reg_wdata,
  output logic [2*W-1:0]  reg_rdata,
  input  logic            evt_in_a,
  input  logic            evt_in_b,
  output logic            irq_a,
  output logic            irq_b,
  output logic            pwm_a,
  output logic            pwm_b
);
  localparam int CW = 2 * W;
  localparam logic [W-1:0] VAL_RST = {W{1'b1}};
  localparam logic [W-1:0] ZH      = '0;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_ns;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ns = rs_q[1];

  // register state
  logic [W-1:0] load_a_q, load_b_q, match_a_q, match_b_q;
  logic [W-1:0] load_a_d, load_b_d, match_a_d, match_b_d;
  logic         joined_q, joined_d;
  tmr_mode_e    mode_a_q, mode_a_d, mode_b_q, mode_b_d;
  logic         en_a_q, en_a_d, en_b_q, en_b_d;
  logic         mask_a_q, mask_a_d, mask_b_q, mask_b_d;
  logic         st_a_q, st_a_d, st_b_q, st_b_d;

  logic         wr_cfg, wr_ld_a, wr_mt_a, wr_ld_b, wr_mt_b, wr_clr;
  logic         evt_a, evt_b, stop_a, stop_b;
  logic [CW-1:0] load_a_x, match_a_x, cnt_a;
  logic [W-1:0]  cnt_b;
  logic [1:0]    evt_in, rise;

  assign wr_cfg = reg_we && (reg_addr == ADR_CFG);
  assign wr_ld_a = reg_we && (reg_addr == ADR_LOAD_A);
  assign wr_mt_a = reg_we && (reg_addr == ADR_MATCH_A);
  assign wr_ld_b = reg_we && (reg_addr == ADR_LOAD_B);
  assign wr_mt_b = reg_we && (reg_addr == ADR_MATCH_B) && !joined_q;
  assign wr_clr  = reg_we && (reg_addr == ADR_ICLR);

  always_comb begin
    load_a_d  = load_a_q;
    load_b_d  = load_b_q;
    match_a_d = match_a_q;
    match_b_d = match_b_q;
    joined_d  = joined_q;
    mode_a_d  = mode_a_q;
    mode_b_d  = mode_b_q;
    mask_a_d  = mask_a_q;
    mask_b_d  = mask_b_q;
    en_a_d    = stop_a ? 1'b0 : en_a_q;
    en_b_d    = stop_b ? 1'b0 : en_b_q;
    if (wr_cfg) begin
      joined_d = reg_wdata[0];
      mode_a_d = tmr_mode_e'(reg_wdata[2:1]);
      mode_b_d = tmr_mode_e'(reg_wdata[4:3]);
      en_a_d   = reg_wdata[5];
      en_b_d   = reg_wdata[6];
      mask_a_d = reg_wdata[7];
      mask_b_d = reg_wdata[8];
    end
    if (wr_ld_a) begin
      load_a_d = reg_wdata[W-1:0];
      if (joined_q) load_b_d = reg_wdata[CW-1:W];
    end
    if (wr_ld_b) load_b_d = reg_wdata[W-1:0];
    if (wr_mt_a) begin
      match_a_d = reg_wdata[W-1:0];
      if (joined_q) match_b_d = reg_wdata[CW-1:W];
    end
    if (wr_mt_b) match_b_d = reg_wdata[W-1:0];
    st_a_d = (st_a_q & ~(wr_clr & reg_wdata[0])) | evt_a;
    st_b_d = (st_b_q & ~(wr_clr & reg_wdata[1])) | evt_b;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      load_a_q  <= VAL_RST;
      load_b_q  <= VAL_RST;
      match_a_q <= VAL_RST;
      match_b_q <= VAL_RST;
      joined_q  <= 1'b0;
      mode_a_q  <= MODE_ONESHOT;
      mode_b_q  <= MODE_ONESHOT;
      en_a_q    <= 1'b0;
      en_b_q    <= 1'b0;
      mask_a_q  <= 1'b0;
      mask_b_q  <= 1'b0;
      st_a_q    <= 1'b0;
      st_b_q    <= 1'b0;
    end else begin
      load_a_q  <= load_a_d;
      load_b_q  <= load_b_d;
      match_a_q <= match_a_d;
      match_b_q <= match_b_d;
      joined_q  <= joined_d;
      mode_a_q  <= mode_a_d;
      mode_b_q  <= mode_b_d;
      en_a_q    <= en_a_d;
      en_b_q    <= en_b_d;
      mask_a_q  <= mask_a_d;
      mask_b_q  <= mask_b_d;
      st_a_q    <= st_a_d;
      st_b_q    <= st_b_d;
    end
  end

  // event input synchronizers, one per half
  assign evt_in = {evt_in_b, evt_in_a};
  for (genvar gi = 0; gi < 2; gi++) begin : g_sync
    tmr_edge_sync u_sync (
      .clk  (clk),
      .rst_n(rst_ns),
      .din  (evt_in[gi]),
      .rise (rise[gi])
    );
  end

  // timer A is full width; its upper half is live only when joined
  assign load_a_x  = joined_q ? {load_b_q, load_a_q}  : {ZH, load_a_q};
  assign match_a_x = joined_q ? {match_b_q, match_a_q} : {ZH, match_a_q};

  tmr_core #(.N(CW)) u_core_a (
    .clk       (clk),
    .rst_n     (rst_ns),
    .en        (en_a_q),
    .mode      (mode_a_q),
    .load_val  (load_a_x),
    .match_val (match_a_x),
    .edge_pulse(rise[0]),
    .match_evt (evt_a),
    .stop      (stop_a),
    .pwm_o     (pwm_a),
    .cnt_o     (cnt_a)
  );

  tmr_core #(.N(W)) u_core_b (
    .clk       (clk),
    .rst_n     (rst_ns),
    .en        (en_b_q && !joined_q),
    .mode      (mode_b_q),
    .load_val  (load_b_q),
    .match_val (match_b_q),
    .edge_pulse(rise[1]),
    .match_evt (evt_b),
    .stop      (stop_b),
    .pwm_o     (pwm_b),
    .cnt_o     (cnt_b)
  );

  assign irq_a = st_a_q & mask_a_q;
  assign irq_b = st_b_q & mask_b_q;

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      ADR_CFG:     reg_rdata[8:0] = {mask_b_q, mask_a_q, en_b_q, en_a_q,
                                     mode_b_q, mode_a_q, joined_q};
      ADR_LOAD_A:  reg_rdata = load_a_x;
      ADR_MATCH_A: reg_rdata = match_a_x;
      ADR_LOAD_B:  reg_rdata = {ZH, load_b_q};
      ADR_MATCH_B: reg_rdata = {ZH, match_b_q};
      ADR_STATUS:  reg_rdata[1:0] = {st_b_q, st_a_q};
      ADR_COUNT:   reg_rdata = joined_q ? cnt_a : {cnt_b, cnt_a[W-1:0]};
      default:     reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/split_match_timer_chk.sv
module split_match_timer_chk
  import tmr_pkg::*;
#(
  parameter int W = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_we,
  input logic [2:0]    reg_addr,
  input logic [2*W-1:0] reg_rdata,
  input logic          joined,
  input logic [W-1:0]  match_b,
  input logic          en_a,
  input tmr_mode_e     mode_a,
  input logic [2*W-1:0] cnt_a,
  input logic [2*W-1:0] match_a_x,
  input logic          stop_a,
  input logic          evt_a,
  input logic          st_a,
  input logic          pwm_a
);
  p_bmatch_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (joined && reg_we && reg_addr == ADR_MATCH_B) |=> $stable(match_b));

  p_reserved_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADR_MATCH_B || (!joined && reg_addr == ADR_MATCH_A))
      |-> (reg_rdata[2*W-1:W] == '0));

  p_edge_selfstop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_a && !(reg_we && reg_addr == ADR_CFG)) |=> !en_a);

  p_pwm_zero_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en_a && mode_a == MODE_PWM && match_a_x == '0) |=> pwm_a);

  p_status_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    evt_a |=> st_a);

  p_oneshot_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en_a && mode_a == MODE_ONESHOT && cnt_a == '0 &&
     !(reg_we && reg_addr == ADR_CFG)) |=> (cnt_a == '0));
endmodule

bind split_match_timer split_match_timer_chk i_chk (
  .clk      (clk),
  .rst_n    (rst_ns),
  .reg_we   (reg_we),
  .reg_addr (reg_addr),
  .reg_rdata(reg_rdata),
  .joined   (joined_q),
  .match_b  (match_b_q),
  .en_a     (en_a_q),
  .mode_a   (mode_a_q),
  .cnt_a    (cnt_a),
  .match_a_x(match_a_x),
  .stop_a   (stop_a),
  .evt_a    (evt_a),
  .st_a     (st_a_q),
  .pwm_a    (pwm_a)
);

// File: tb/test_split_match_timer.sv
module test_split_match_timer;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        evt_in_a = 1'b0, evt_in_b = 1'b0;
  logic        irq_a, irq_b, pwm_a, pwm_b;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  split_match_timer i_split_match_timer (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .evt_in_a(evt_in_a), .evt_in_b(evt_in_b),
    .irq_a(irq_a), .irq_b(irq_b), .pwm_a(pwm_a), .pwm_b(pwm_b)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WDOG && !done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  function automatic logic [31:0] cfgv(int j, int ma, int mb, int ea, int eb, int ka, int kb);
    return 32'(j | (ma << 1) | (mb << 3) | (ea << 5) | (eb << 6) | (ka << 7) | (kb << 8));
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic cyc_n(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic teardown();
    wr(3'd0, 32'd0);
    wr(3'd6, 32'd3);
  endtask

  task automatic pulse(bit b);
    if (b) evt_in_b = 1'b1; else evt_in_a = 1'b1;
    cyc_n(3);
    evt_in_a = 1'b0; evt_in_b = 1'b0;
    cyc_n(3);
  endtask

  logic [31:0] v;

  initial begin
    void'($urandom(32'd1234));
    cyc_n(3);
    rst_n = 1'b1;
    cyc_n(4);

    // R1: reset values
    rd(3'd1, v); check("R1 load_a", v, 32'h0000FFFF);
    rd(3'd2, v); check("R1 match_a", v, 32'h0000FFFF);
    rd(3'd4, v); check("R1 match_b", v, 32'h0000FFFF);
    rd(3'd0, v); check("R1 cfg", v, 32'd0);
    rd(3'd5, v); check("R1 status", v, 32'd0);
    check("R1 outputs", {28'd0, irq_a, irq_b, pwm_a, pwm_b}, 32'd0);

    // R9: reserved upper half in split mode
    wr(3'd2, 32'hABCD_1234);
    rd(3'd2, v); check("R9 match_a upper", v, 32'h0000_1234);
    wr(3'd3, 32'h5A5A_0042);
    rd(3'd3, v); check("R9 load_b upper", v, 32'h0000_0042);

    // R2 R3 R10: one-shot, random
    for (int it = 0; it < 5; it++) begin
      int ld, mt, d;
      ld = 2 + int'($urandom % 39);
      mt = int'($urandom % (ld + 1));
      if (it == 0) mt = ld;
      if (it == 1) mt = 0;
      d = ld - mt + 1;
      wr(3'd1, 32'(ld)); wr(3'd2, 32'(mt));
      wr(3'd0, cfgv(0, 0, 0, 1, 0, 1, 0));
      cyc_n(d - 1);
      rd(3'd5, v); check("R2 oneshot early", v, 32'd0);
      cyc_n(1);
      rd(3'd5, v); check("R2 oneshot match", v, 32'd1);
      check("R10 irq_a masked on", {31'd0, irq_a}, 32'd1);
      cyc_n(ld + 3);
      wr(3'd6, 32'd1);
      cyc_n(ld + 3);
      rd(3'd5, v); check("R3 no second event", v, 32'd0);
      rd(3'd7, v); check("R3 holds zero", {16'd0, v[15:0]}, 32'd0);
      teardown();
    end

    // R4: periodic, random
    for (int it = 0; it < 5; it++) begin
      int ld, mt, d;
      ld = 2 + int'($urandom % 29);
      mt = int'($urandom % (ld + 1));
      d = ld - mt + 1;
      wr(3'd1, 32'(ld)); wr(3'd2, 32'(mt));
      wr(3'd0, cfgv(0, 1, 0, 1, 0, 1, 0));
      cyc_n(d - 1);
      rd(3'd5, v); check("R4 periodic early", v, 32'd0);
      cyc_n(1);
      rd(3'd5, v); check("R4 periodic first", v, 32'd1);
      wr(3'd6, 32'd1);
      cyc_n(ld - 1);
      rd(3'd5, v); check("R4 periodic gap", v, 32'd0);
      cyc_n(1);
      rd(3'd5, v); check("R4 periodic second", v, 32'd1);
      teardown();
    end

    // R10: mask off, selective clear, set beats nothing else
    wr(3'd1, 32'd5); wr(3'd2, 32'd5);
    wr(3'd0, cfgv(0, 0, 0, 1, 0, 0, 0));
    cyc_n(2);
    rd(3'd5, v); check("R10 status set", v, 32'd1);
    check("R10 irq_a masked off", {31'd0, irq_a}, 32'd0);
    wr(3'd6, 32'd2);
    rd(3'd5, v); check("R10 clear other bit", v, 32'd1);
    wr(3'd6, 32'd1);
    rd(3'd5, v); check("R10 clear own bit", v, 32'd0);
    teardown();

    // R5: edge-count on A, load 10 match 4 -> 6 edges
    wr(3'd1, 32'd10); wr(3'd2, 32'd4);
    wr(3'd0, cfgv(0, 2, 0, 1, 0, 1, 0));
    for (int i = 0; i < 5; i++) pulse(0);
    cyc_n(2);
    rd(3'd5, v); check("R5 no event after 5 edges", v, 32'd0);
    rd(3'd7, v); check("R5 count after 5 edges", {16'd0, v[15:0]}, 32'd5);
    pulse(0); cyc_n(2);
    rd(3'd5, v); check("R5 event after 6 edges", v, 32'd1);
    rd(3'd0, v); check("R5 enable cleared", {31'd0, v[5]}, 32'd0);
    teardown();

    // R6: edge-count invalid on B, load 3 match 3
    wr(3'd3, 32'd3); wr(3'd4, 32'd3);
    wr(3'd0, cfgv(0, 0, 2, 0, 1, 0, 1));
    for (int i = 0; i < 4; i++) pulse(1);
    cyc_n(2);
    rd(3'd5, v); check("R6 no event", v, 32'd0);
    rd(3'd7, v); check("R6 count unchanged", {16'd0, v[31:16]}, 32'd3);
    rd(3'd0, v); check("R6 still enabled", {31'd0, v[6]}, 32'd1);
    teardown();

    // R7: PWM on B
    for (int it = 0; it < 5; it++) begin
      int ld, mt, hi, exp_hi;
      ld = 2 + int'($urandom % 20);
      mt = int'($urandom % (ld + 1));
      if (it == 0) begin ld = 9; mt = 3; end
      if (it == 1) mt = 0;
      wr(3'd3, 32'(ld)); wr(3'd4, 32'(mt));
      wr(3'd0, cfgv(0, 0, 3, 0, 1, 0, 0));
      cyc_n(2 * (ld + 1));
      hi = 0;
      for (int i = 0; i < 2 * (ld + 1); i++) begin
        cyc_n(1);
        if (pwm_b) hi++;
      end
      exp_hi = (mt == 0) ? 2 * (ld + 1) : 2 * (ld - mt);
      check("R7 pwm high cycles", 32'(hi), 32'(exp_hi));
      teardown();
    end

    // R8: joined mode
    wr(3'd0, cfgv(1, 1, 0, 0, 0, 1, 0));
    wr(3'd1, 32'h0001_0002);
    wr(3'd2, 32'h0001_0000);
    wr(3'd4, 32'h0000_1234);
    rd(3'd4, v); check("R8 match_b write ignored", v, 32'h0000_0001);
    rd(3'd2, v); check("R8 match_a joined read", v, 32'h0001_0000);
    rd(3'd3, v); check("R8 load_b upper fill", v, 32'h0000_0001);
    wr(3'd0, cfgv(1, 1, 0, 1, 0, 1, 0));
    cyc_n(2);
    rd(3'd5, v); check("R8 joined early", v, 32'd0);
    cyc_n(1);
    rd(3'd5, v); check("R8 joined match", v, 32'd1);
    teardown();
    wr(3'd4, 32'h0000_0077);
    rd(3'd4, v); check("R8 match_b split write", v, 32'h0000_0077);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule